// File: doc/BRIEF.md
# ADC Conversion Sequencing Controller

This block sequences successive-approximation conversions for an analog-to-digital converter and times them in conversion-clock ticks. Software uses a small word-aligned register window to pick an input channel, set the resolution, the sample-time extension, hardware averaging and the clock prescaler, and then start a conversion. The analog converter itself is not modelled. A sample input port supplies the raw word, and the block captures that word when the timer reaches the end of the conversion.

A conversion lasts a fixed 6-tick setup plus N repetitions of a 25-tick base period extended by a long-sample adder L. Each tick is one prescaled conversion-clock period. When a conversion ends, the block raises a completion flag and latches a masked result. An interrupt level follows the flag when the interrupt is enabled. A continuous mode chains conversions back to back. A calibration run uses the same timer, completes through the same flag, and reports a failure if the configuration is disturbed while it runs.

Top module: `adc_seq_top`

## Requirements
- R1: Registers sit at byte offsets 0x00 (channel control), 0x08 (status), 0x0C (result), 0x14 (configuration), 0x18 (general control) and 0x1C (general status). An address that is not a multiple of 4, or is above 0x30, reads as zero and ignores writes. Unmapped valid words also read as zero.
- R2: In channel control, bits 4:0 hold the channel and bit 7 holds the interrupt enable. Writing a channel other than 0x1F starts a conversion and restarts any conversion in progress. Writing 0x1F cancels a conversion in progress and starts nothing.
- R3: The completion flag rises exactly D×(6 + N×(25 + L)) clock cycles after the edge that accepts the start write. N is 1 when general-control bit 5 is clear. When bit 5 is set, N is 4, 8, 16 or 32, chosen by configuration bits 15:14 = 0..3.
- R4: L is 3 + 2s when configuration bit 4 is clear and 13 + 4s when bit 4 is set, where s is configuration bits 9:8.
- R5: D is 1, 2, 4 or 8, chosen by configuration bits 6:5. D is doubled when configuration bits 1:0 equal 01, so 01 with divide-by-8 gives 16.
- R6: The result is the sample input masked according to configuration bits 3:2: 00 keeps 8 bits, 01 keeps 10 bits, and 10 or 11 keep 12 bits.
- R7: Status bit 0 is the completion flag. Reading the result register clears the flag. The result register changes only when a conversion completes.
- R8: When configuration bit 16 is clear, a completion that finds the flag still set keeps the old result. When bit 16 is set, the new result overwrites the old one.
- R9: While general-control bit 6 is set, each completion restarts a conversion at once. After the bit is cleared, the conversion in progress finishes and no further conversion starts.
- R10: Writing general-control bit 7 as 1 starts a calibration run lasting CAL_TICKS×D cycles. The run aborts any conversion in progress and ignores conversion starts while it runs. Bit 7 reads as 1 during the run. The completion flag is set at the end of the run and the result is left unchanged.
- R11: A configuration-register write during calibration sets general-status bit 1. Starting a new calibration clears it.
- R12: The interrupt output is high exactly while the completion flag and the interrupt enable are both set.
- R13: After reset, channel control reads 0x1F, every other register reads zero, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and conversion reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (used for read side effects) |
| busAddr | input | ADDR_W | Byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| sampleIn | input | SAMPLE_W | Raw converter word captured at the end of a conversion |
| irqOut | output | 1 | Completion interrupt level |

## Verification
A wrong tick limit or prescaler count shows at the ports as a completion flag that rises early or late, so the bench measures the exact cycle of that rise against the timing formula for every sample-time code, averaging count and divider. A stale flag or a mis-gated result store shows up on the first result read after the faulty completion. A stuck calibration state shows up within one calibration period, as a general-control bit 7 that never clears or a completion that never arrives.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  // word indices (byte offset / 4)
  localparam int IDX_CHCTL = 0;
  localparam int IDX_STAT  = 2;
  localparam int IDX_RES   = 3;
  localparam int IDX_CFG   = 5;
  localparam int IDX_GC    = 6;
  localparam int IDX_GS    = 7;
  localparam int LAST_OFFSET = 'h30;
  localparam int RES_W = 12;
  localparam int MAX_CONV_TICKS = 6 + 32 * (25 + 25);
  localparam logic [4:0] CHAN_OFF = 5'h1F;
  localparam logic [16:0] CFG_MASK = 17'h1C37F;

  typedef struct packed {
    logic startConv;
    logic abortConv;
    logic startCal;
    logic resultRead;
  } ctrlStrobes_t;

  typedef struct packed {
    logic       ovwEn;
    logic [1:0] avgSel;
    logic [1:0] lsSel;
    logic [1:0] preDiv;
    logic       lsEn;
    logic [1:0] resSel;
    logic [1:0] clkSrc;
  } cfgFields_t;

  function automatic cfgFields_t unpackCfg(logic [16:0] w);
    cfgFields_t c;
    c.ovwEn  = w[16];
    c.avgSel = w[15:14];
    c.lsSel  = w[9:8];
    c.preDiv = w[6:5];
    c.lsEn   = w[4];
    c.resSel = w[3:2];
    c.clkSrc = w[1:0];
    return c;
  endfunction

  function automatic logic [10:0] convTicks(cfgFields_t c, logic avgEn);
    logic [5:0] n;
    logic [4:0] l;
    n = avgEn ? (6'd4 << c.avgSel) : 6'd1;
    l = c.lsEn ? 5'd13 + {1'b0, c.lsSel, 2'b00} : 5'd3 + {2'b00, c.lsSel, 1'b0};
    return 11'd6 + 11'(n) * (11'd25 + 11'(l));
  endfunction

  function automatic logic [4:0] preFactor(cfgFields_t c);
    logic [4:0] f;
    f = 5'd1 << c.preDiv;
    if (c.clkSrc == 2'b01) f = f << 1;
    return f;
  endfunction
endpackage

// File: rtl/adc_seq_ctl.sv
module adc_seq_ctl
  import adc_seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  input  logic              doneFlag,
  input  logic [RES_W-1:0]  resultVal,
  input  logic              calBusy,
  output ctrlStrobes_t      strobes,
  output logic [16:0]       cfgWord,
  output logic              avgEn,
  output logic              contEn,
  output logic              intEn,
  output logic              calFail,
  output logic [31:0]       busRdData
);
  localparam int IDX_W = ADDR_W - 2;

  logic             addrOk;
  logic [IDX_W-1:0] wordIdx;
  logic [4:0]       chanSel;
  logic             wrChctl, wrCfg, wrGc;

  assign addrOk  = (busAddr[1:0] == 2'b00) && (busAddr <= ADDR_W'(LAST_OFFSET));
  assign wordIdx = busAddr[ADDR_W-1:2];
  assign wrChctl = busWrEn && addrOk && (wordIdx == IDX_W'(IDX_CHCTL));
  assign wrCfg   = busWrEn && addrOk && (wordIdx == IDX_W'(IDX_CFG));
  assign wrGc    = busWrEn && addrOk && (wordIdx == IDX_W'(IDX_GC));

  always_comb begin
    strobes.startConv  = wrChctl && (busWrData[4:0] != CHAN_OFF) && !calBusy;
    strobes.abortConv  = wrChctl && (busWrData[4:0] == CHAN_OFF);
    strobes.startCal   = wrGc && busWrData[7] && !calBusy;
    strobes.resultRead = busRdEn && addrOk && (wordIdx == IDX_W'(IDX_RES));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chanSel <= CHAN_OFF;
      intEn   <= 1'b0;
      cfgWord <= '0;
      avgEn   <= 1'b0;
      contEn  <= 1'b0;
      calFail <= 1'b0;
    end else begin
      if (wrChctl) begin
        chanSel <= busWrData[4:0];
        intEn   <= busWrData[7];
      end
      if (wrCfg) cfgWord <= busWrData[16:0] & CFG_MASK;
      if (wrGc) begin
        avgEn  <= busWrData[5];
        contEn <= busWrData[6];
      end
      if (strobes.startCal)      calFail <= 1'b0;
      else if (calBusy && wrCfg) calFail <= 1'b1;
    end
  end

  always_comb begin
    busRdData = '0;
    if (addrOk) begin
      case (int'(wordIdx))
        IDX_CHCTL: busRdData = {24'd0, intEn, 2'b00, chanSel};
        IDX_STAT:  busRdData = {31'd0, doneFlag};
        IDX_RES:   busRdData = 32'(resultVal);
        IDX_CFG:   busRdData = {15'd0, cfgWord};
        IDX_GC:    busRdData = {24'd0, calBusy, contEn, avgEn, 5'd0};
        IDX_GS:    busRdData = {30'd0, calFail, 1'b0};
        default:   busRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int CAL_TICKS = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrlStrobes_t        strobes,
  input  cfgFields_t          cfg,
  input  logic                avgEn,
  input  logic                contEn,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic                doneFlag,
  output logic [RES_W-1:0]    resultVal,
  output logic                convBusy,
  output logic                calBusy
);
  localparam int LIMIT_MAX = (MAX_CONV_TICKS > CAL_TICKS) ? MAX_CONV_TICKS : CAL_TICKS;
  localparam int CNT_W     = $clog2(LIMIT_MAX + 1);

  logic [4:0]       preCnt;
  logic [4:0]       divF;
  logic [CNT_W-1:0] tickCnt, tickLim, convLen;
  logic             running, tick, lastTick, evtEnd, convEnd, calEnd;
  logic [RES_W-1:0] maskedSample;

  assign divF     = preFactor(cfg);
  assign convLen  = CNT_W'(convTicks(cfg, avgEn));
  assign running  = convBusy || calBusy;
  assign tick     = running && (preCnt == divF - 5'd1);
  assign lastTick = (tickCnt == tickLim - CNT_W'(1));
  assign evtEnd   = tick && lastTick &&
                    !(strobes.startCal || strobes.startConv || strobes.abortConv);
  assign convEnd  = evtEnd && convBusy;
  assign calEnd   = evtEnd && calBusy;

  always_comb begin
    case (cfg.resSel)
      2'b00:   maskedSample = RES_W'(sampleIn[7:0]);
      2'b01:   maskedSample = RES_W'(sampleIn[9:0]);
      default: maskedSample = sampleIn[RES_W-1:0];
    endcase
  end

  // sequencing timer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      convBusy <= 1'b0;
      calBusy  <= 1'b0;
      preCnt   <= '0;
      tickCnt  <= '0;
      tickLim  <= '0;
    end else if (strobes.startCal) begin
      calBusy  <= 1'b1;
      convBusy <= 1'b0;
      preCnt   <= '0;
      tickCnt  <= '0;
      tickLim  <= CNT_W'(CAL_TICKS);
    end else if (strobes.startConv) begin
      convBusy <= 1'b1;
      preCnt   <= '0;
      tickCnt  <= '0;
      tickLim  <= convLen;
    end else if (strobes.abortConv) begin
      convBusy <= 1'b0;
    end else if (running) begin
      preCnt <= tick ? 5'd0 : preCnt + 5'd1;
      if (tick) begin
        if (lastTick) begin
          tickCnt <= '0;
          if (calBusy)     calBusy  <= 1'b0;
          else if (contEn) tickLim  <= convLen;
          else             convBusy <= 1'b0;
        end else begin
          tickCnt <= tickCnt + CNT_W'(1);
        end
      end
    end
  end

  // completion flag and result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      doneFlag  <= 1'b0;
      resultVal <= '0;
    end else begin
      if (convEnd || calEnd)       doneFlag <= 1'b1;
      else if (strobes.resultRead) doneFlag <= 1'b0;
      if (convEnd && (!doneFlag || cfg.ovwEn || strobes.resultRead))
        resultVal <= maskedSample;
    end
  end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SAMPLE_W  = 16,
  parameter int CAL_TICKS = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic                irqOut
);
  ctrlStrobes_t     strobes;
  cfgFields_t       cfg;
  logic [16:0]      cfgWord;
  logic             avgEn, contEn, intEn, calFail;
  logic             doneFlag, convBusy, calBusy;
  logic [RES_W-1:0] resultVal;

  assign cfg    = unpackCfg(cfgWord);
  assign irqOut = doneFlag && intEn;

  adc_seq_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .doneFlag(doneFlag),
    .resultVal(resultVal), .calBusy(calBusy), .strobes(strobes),
    .cfgWord(cfgWord), .avgEn(avgEn), .contEn(contEn), .intEn(intEn),
    .calFail(calFail), .busRdData(busRdData)
  );

  adc_seq_dp #(.SAMPLE_W(SAMPLE_W), .CAL_TICKS(CAL_TICKS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .cfg(cfg), .avgEn(avgEn),
    .contEn(contEn), .sampleIn(sampleIn), .doneFlag(doneFlag),
    .resultVal(resultVal), .convBusy(convBusy), .calBusy(calBusy)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [16:0]       cfgWord,
  input logic              doneFlag,
  input logic [11:0]       resultVal,
  input logic              resultRead,
  input logic              convBusy,
  input logic              calBusy,
  input logic              calFail,
  input logic              intEn,
  input logic              irqOut
);
  logic badAddr;
  assign badAddr = (busAddr[1:0] != 2'b00) || (busAddr > ADDR_W'('h30));

  // R1
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && badAddr) |=> $stable(cfgWord));

  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(doneFlag) |-> $past(resultRead));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !convBusy |=> $stable(resultVal));

  // R10
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(convBusy && calBusy));

  // R11
  fail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(calFail) |-> $past(calBusy));

  // R12
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqOut) |-> ($rose(doneFlag) || $rose(intEn)));
endmodule

bind adc_seq_top adc_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busAddr(busAddr),
  .cfgWord(cfgWord), .doneFlag(doneFlag), .resultVal(resultVal),
  .resultRead(strobes.resultRead), .convBusy(convBusy), .calBusy(calBusy),
  .calFail(calFail), .intEn(intEn), .irqOut(irqOut)
);

// File: tb/test_adc_seq_top.sv
module test_adc_seq_top;
  localparam int CAL = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [15:0] sampleIn = '0;
  logic        irqOut;

  int cyc = 0, lastWr = 0, errors = 0, checks = 0;

  adc_seq_top #(.ADDR_W(8), .SAMPLE_W(16), .CAL_TICKS(CAL)) i_adc_seq_top (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .sampleIn(sampleIn), .irqOut(irqOut)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<=190000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0; lastWr = cyc;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRdEn = 1'b1; #1 d = busRdData;
    @(negedge clk); busRdEn = 1'b0;
  endtask

  task automatic waitDone(input int base, output int delta);
    int n = 0;
    busAddr = 8'h08; #1;
    while (!busRdData[0] && n < 30000) begin
      @(negedge clk); #1; n++;
    end
    delta = cyc - base;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int expT(int lsEn, int s, int avgOn, int a);
    int nAvg = avgOn ? (4 << a) : 1;
    int l = lsEn ? 13 + 4 * s : 3 + 2 * s;
    return 6 + nAvg * (25 + l);
  endfunction

  task automatic runConv(input string req, input logic [31:0] cfgV, input logic [31:0] gcV,
                         input int expCycles);
    int d; logic [31:0] t;
    wr(8'h14, cfgV); wr(8'h18, gcV); wr(8'h00, 32'h03);
    waitDone(lastWr, d);
    chk(req, d, expCycles);
    rd(8'h0C, t);
  endtask

  initial begin
    logic [31:0] v;
    int d, base;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R13 / R2 reset state
    rd(8'h00, v); chk("R2 reset channel", v, 32'h1F);
    rd(8'h14, v); chk("R13 reset cfg", v, 0);
    rd(8'h18, v); chk("R13 reset gc", v, 0);
    rd(8'h08, v); chk("R13 reset stat", v, 0);
    rd(8'h1C, v); chk("R13 reset gs", v, 0);
    rd(8'h0C, v); chk("R13 reset result", v, 0);
    chk("R13 reset irq", irqOut, 0);

    // R4 all sample-time codes, divider 1, no averaging
    for (int e = 0; e < 2; e++)
      for (int s = 0; s < 4; s++)
        runConv("R4 sample adder timing", (e << 4) | (s << 8) | 32'h8, 0, expT(e, s, 0, 0));

    // R3 averaging counts, and averaging select ignored when disabled
    for (int a = 0; a < 4; a++)
      runConv("R3 averaged timing", (a << 14) | 32'h8, 32'h20, expT(0, 0, 1, a));
    runConv("R3 avg select without enable", (32'h3 << 14) | 32'h8, 0, expT(0, 0, 0, 0));

    // R5 prescaler
    for (int p = 0; p < 4; p++)
      runConv("R5 prescale", (p << 5) | 32'h8, 0, expT(0, 0, 0, 0) * (1 << p));
    runConv("R5 halved source div8", (3 << 5) | 32'h9, 0, expT(0, 0, 0, 0) * 16);
    runConv("R5 halved source div1", 32'h9, 0, expT(0, 0, 0, 0) * 2);

    // R6 resolution masking
    sampleIn = 16'hABCD;
    for (int r = 0; r < 4; r++) begin
      wr(8'h14, r << 2); wr(8'h00, 32'h05);
      waitDone(lastWr, d);
      rd(8'h0C, v);
      chk("R6 result mask", v, (r == 0) ? 32'hCD : (r == 1) ? 32'h3CD : 32'hBCD);
      rd(8'h08, v); chk("R7 flag cleared by result read", v, 0);
    end

    // R8 overwrite control
    wr(8'h14, 32'h8);
    sampleIn = 16'h0111; wr(8'h00, 32'h02); waitDone(lastWr, d);
    sampleIn = 16'h0222; wr(8'h00, 32'h02); idle(expT(0, 0, 0, 0) + 5);
    rd(8'h0C, v); chk("R8 no overwrite keeps old", v, 32'h111);
    wr(8'h14, 32'h10008);
    sampleIn = 16'h0333; wr(8'h00, 32'h02); waitDone(lastWr, d);
    sampleIn = 16'h0444; wr(8'h00, 32'h02); idle(expT(0, 0, 0, 0) + 5);
    rd(8'h0C, v); chk("R8 overwrite takes new", v, 32'h444);

    // R9 continuous mode
    wr(8'h14, 32'h8); sampleIn = 16'h0055;
    wr(8'h18, 32'h40); wr(8'h00, 32'h01); base = lastWr;
    waitDone(base, d); chk("R9 first completion", d, 34);
    sampleIn = 16'h0066; rd(8'h0C, v); chk("R9 first result", v, 32'h55);
    waitDone(base, d); chk("R9 chained completion", d, 68);
    rd(8'h0C, v); chk("R9 second result", v, 32'h66);
    wr(8'h18, 32'h00);
    waitDone(base, d); chk("R9 in-flight finishes", d, 102);
    rd(8'h0C, v); idle(80);
    rd(8'h08, v); chk("R9 no restart after clear", v, 0);

    // R2 cancel and idle disable code
    wr(8'h00, 32'h04); idle(5); wr(8'h00, 32'h1F); idle(60);
    rd(8'h08, v); chk("R2 cancel stops conversion", v, 0);
    wr(8'h00, 32'h1F); idle(60);
    rd(8'h08, v); chk("R2 disable code starts nothing", v, 0);
    rd(8'h00, v); chk("R2 channel readback", v, 32'h1F);

    // R12 interrupt level
    wr(8'h00, 32'h83);
    chk("R12 irq low while converting", irqOut, 0);
    waitDone(lastWr, d); chk("R12 irq high on done", irqOut, 1);
    rd(8'h0C, v); chk("R12 irq low after read", irqOut, 0);
    wr(8'h00, 32'h03); waitDone(lastWr, d);
    chk("R12 irq masked", irqOut, 0);
    rd(8'h0C, v);

    // R10 calibration
    sampleIn = 16'h0777;
    wr(8'h00, 32'h03); waitDone(lastWr, d); rd(8'h0C, v);
    wr(8'h18, 32'h80); base = lastWr;
    rd(8'h18, v); chk("R10 busy bit reads set", v, 32'h80);
    waitDone(base, d); chk("R10 calibration length", d, CAL);
    rd(8'h18, v); chk("R10 busy bit clears", v, 0);
    rd(8'h1C, v); chk("R11 no failure when untouched", v, 0);
    rd(8'h0C, v); chk("R10 result untouched", v, 32'h777);

    // R10 calibration aborts conversion
    wr(8'h14, 32'h318);
    sampleIn = 16'h0999;
    wr(8'h00, 32'h03); idle(3);
    wr(8'h18, 32'h80); base = lastWr;
    wr(8'h00, 32'h03);
    waitDone(base, d); chk("R10 cal preempts conversion", d, CAL);
    rd(8'h0C, v); chk("R10 aborted result not stored", v, 32'h777);
    idle(100);
    rd(8'h08, v); chk("R10 no late completion", v, 0);

    // R11 failure flag
    wr(8'h18, 32'h80); base = lastWr;
    wr(8'h14, 32'h8);
    waitDone(base, d); rd(8'h0C, v);
    rd(8'h1C, v); chk("R11 failure set", v, 32'h2);
    wr(8'h18, 32'h80); base = lastWr;
    rd(8'h1C, v); chk("R11 failure cleared on restart", v, 0);
    waitDone(base, d); rd(8'h0C, v);

    // R1 address validity
    wr(8'h15, 32'hFFFF); rd(8'h14, v); chk("R1 unaligned write ignored", v, 32'h8);
    wr(8'h34, 32'hFFFF); rd(8'h34, v); chk("R1 beyond range reads zero", v, 0);
    rd(8'h17, v); chk("R1 unaligned read zero", v, 0);
    rd(8'h04, v); chk("R1 unmapped word zero", v, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule